// File: doc/BRIEF.md
# Text Row Attribute Change Decoder

This block turns the attribute change list for one character row into an attribute for each column as the row is scanned out. A display controller first signals the start of a row and then supplies a short list of change pairs. Each pair names a column and the attribute that takes effect there. The controller then steps through the columns with an advance strobe. At every column the block shows the attribute that applies there: the latest change at or before that column, or a default value when no change has happened yet.

The column byte is checked before a pair is stored. Only the low seven bits are used. A column past the right edge of the line is dropped rather than folded back to column 0, and this includes the reserved control value 0x60. Each row holds a fixed number of changes. Pairs that arrive after the row is full are discarded. Fetching pairs from memory, interpreting the attribute bits, glyph lookup and video timing all belong to other blocks.

Top module: `rowattr_decoder`

## Requirements
- R1: After reset, and after any cycle in which `row_start` is high, the column position is 0, the shown attribute is `DEFAULT_ATTR` (0x07 by default) and every stored pair of the previous row is discarded.
- R2: An accepted pair with column c and attribute a makes `cur_attr` equal a at column c and at every following column up to the next change. Columns before the first change show `DEFAULT_ATTR`.
- R3: Bit 7 of `pair_col` is ignored, so column byte 0x80+c behaves exactly like c. For example, 0x80 selects column 0.
- R4: A pair whose masked column is 0x50 or greater is dropped without effect. This covers 0x50, the control code 0x60 and 0x7F. Such a pair is not mapped to column 0 and takes no slot.
- R5: Up to 20 valid pairs are accepted per row, and the 20th is included. The 21st and all later pairs of the same row are discarded.
- R6: When two accepted pairs name the same column, the one loaded later decides the attribute.
- R7: At the clock edge where `col_adv` is sampled high, the position moves to the next column. `cur_attr` shows that column's attribute with no further delay.
- R8: `col_adv` at the last column (79) has no effect. Position and attribute stay as they are.
- R9: A pair presented in the same cycle as `row_start` is discarded.
- R10: When `col_adv` and `row_start` are high in the same cycle, the row start wins and the position is column 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| row_start | input | 1 | Starts a new row: clears the pairs and goes to column 0 |
| col_adv | input | 1 | Steps the scan to the next column |
| pair_valid | input | 1 | A change pair is present on pair_col and pair_attr |
| pair_col | input | 8 | Column byte of the pair, only bits 6:0 are used |
| pair_attr | input | 8 | Attribute value of the pair |
| cur_attr | output | 8 | Attribute for the column currently shown |

## Verification
The hardest case to reach is a row at full capacity that also contains duplicate columns and out-of-range or high-bit columns. In that row the only thing that decides whether a late pair survives is how many valid pairs came before it. The random rows therefore draw up to 28 pairs each, with column bytes weighted toward on-line values, values with bit 7 set and values just past the edge. The full-row, duplicate and coinciding-strobe cases are also run as directed rows. Each row is scanned across all 80 columns and compared with a list computed in the bench.

// File: rtl/rowattr_pkg.sv
package rowattr_pkg;
    localparam int LINE_COLS   = 80;
    localparam int PAIR_LIMIT  = 20;
    localparam int COL_IN_BITS = 8;
    localparam int COL_BITS    = 7;
    localparam int ATTR_BITS   = 8;
    localparam logic [ATTR_BITS-1:0] RESET_ATTR = 8'h07;
endpackage

// File: rtl/rowattr_col_filter.sv
module rowattr_col_filter #(
    parameter int COL_IN_W = 8,
    parameter int COL_W    = 7,
    parameter int NUM_COLS = 80
) (
    input  logic                pair_valid,
    input  logic                row_start,
    input  logic [COL_IN_W-1:0] col_raw,
    output logic [COL_W-1:0]    col_idx,
    output logic                accept
);
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(NUM_COLS - 1);

    always_comb begin
        // upper bits beyond the column field are ignored
        col_idx = col_raw[COL_W-1:0];
        // off-line columns are dropped, a pair during row start is dropped
        accept  = pair_valid && !row_start && (col_idx <= LAST_COL);
    end
endmodule

// File: rtl/rowattr_pair_store.sv
module rowattr_pair_store #(
    parameter int MAX_PAIRS = 20,
    parameter int COL_W     = 7,
    parameter int ATTR_W    = 8,
    parameter int CNT_W     = 5
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              row_start,
    input  logic                              wr_en,
    input  logic [COL_W-1:0]                  wr_col,
    input  logic [ATTR_W-1:0]                 wr_attr,
    output logic [CNT_W-1:0]                  count,
    output logic [MAX_PAIRS-1:0][COL_W-1:0]   slot_col,
    output logic [MAX_PAIRS-1:0][ATTR_W-1:0]  slot_attr
);
    localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_PAIRS);

    typedef struct packed {
        logic [CNT_W-1:0]                  cnt;
        logic [MAX_PAIRS-1:0][COL_W-1:0]   col;
        logic [MAX_PAIRS-1:0][ATTR_W-1:0]  attr;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (row_start) begin
            st_d.cnt = '0;
        end else if (wr_en && (st_q.cnt < CAP)) begin
            for (int i = 0; i < MAX_PAIRS; i++) begin
                if (CNT_W'(i) == st_q.cnt) begin
                    st_d.col[i]  = wr_col;
                    st_d.attr[i] = wr_attr;
                end
            end
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count     = st_q.cnt;
    assign slot_col  = st_q.col;
    assign slot_attr = st_q.attr;

    AST_CNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CAP); // R5
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !row_start && st_q.cnt == CAP) |=> (st_q.cnt == CAP)); // R5
    AST_SLOT_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !row_start && st_q.cnt < CAP) |=> (st_q.cnt == $past(st_q.cnt) + CNT_W'(1))); // R5
    AST_ROW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        row_start |=> (st_q.cnt == '0)); // R1
endmodule

// File: rtl/rowattr_match.sv
module rowattr_match #(
    parameter int MAX_PAIRS = 20,
    parameter int COL_W     = 7,
    parameter int ATTR_W    = 8,
    parameter int CNT_W     = 5
) (
    input  logic [COL_W-1:0]                  col_idx,
    input  logic [CNT_W-1:0]                  count,
    input  logic [MAX_PAIRS-1:0][COL_W-1:0]   slot_col,
    input  logic [MAX_PAIRS-1:0][ATTR_W-1:0]  slot_attr,
    output logic                              hit,
    output logic [ATTR_W-1:0]                 hit_attr
);
    logic [MAX_PAIRS-1:0] slot_hit;

    for (genvar g = 0; g < MAX_PAIRS; g++) begin : g_slot
        assign slot_hit[g] = (CNT_W'(g) < count) && (slot_col[g] == col_idx);
    end

    // higher slot index was loaded later and takes precedence
    always_comb begin
        hit      = 1'b0;
        hit_attr = '0;
        for (int i = 0; i < MAX_PAIRS; i++) begin
            if (slot_hit[i]) begin
                hit      = 1'b1;
                hit_attr = slot_attr[i];
            end
        end
    end
endmodule

// File: rtl/rowattr_decoder.sv
module rowattr_decoder #(
    parameter int                                NUM_COLS     = rowattr_pkg::LINE_COLS,
    parameter int                                MAX_PAIRS    = rowattr_pkg::PAIR_LIMIT,
    parameter int                                COL_IN_W     = rowattr_pkg::COL_IN_BITS,
    parameter int                                COL_W        = rowattr_pkg::COL_BITS,
    parameter int                                ATTR_W       = rowattr_pkg::ATTR_BITS,
    parameter logic [rowattr_pkg::ATTR_BITS-1:0] DEFAULT_ATTR = rowattr_pkg::RESET_ATTR
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                row_start,
    input  logic                col_adv,
    input  logic                pair_valid,
    input  logic [COL_IN_W-1:0] pair_col,
    input  logic [ATTR_W-1:0]   pair_attr,
    output logic [ATTR_W-1:0]   cur_attr
);
    localparam int               CNT_W    = $clog2(MAX_PAIRS + 1);
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(NUM_COLS - 1);

    typedef struct packed {
        logic [COL_W-1:0]  pos;
        logic [ATTR_W-1:0] held;
    } scan_t;

    scan_t sc_d, sc_q;

    logic                             wr_en;
    logic [COL_W-1:0]                 wr_col;
    logic [CNT_W-1:0]                 count;
    logic [MAX_PAIRS-1:0][COL_W-1:0]  slot_col;
    logic [MAX_PAIRS-1:0][ATTR_W-1:0] slot_attr;
    logic                             hit;
    logic [ATTR_W-1:0]                hit_attr;

    rowattr_col_filter #(.COL_IN_W(COL_IN_W), .COL_W(COL_W), .NUM_COLS(NUM_COLS)) u_filter (
        .pair_valid (pair_valid),
        .row_start  (row_start),
        .col_raw    (pair_col),
        .col_idx    (wr_col),
        .accept     (wr_en)
    );

    rowattr_pair_store #(.MAX_PAIRS(MAX_PAIRS), .COL_W(COL_W), .ATTR_W(ATTR_W), .CNT_W(CNT_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .row_start (row_start),
        .wr_en     (wr_en),
        .wr_col    (wr_col),
        .wr_attr   (pair_attr),
        .count     (count),
        .slot_col  (slot_col),
        .slot_attr (slot_attr)
    );

    rowattr_match #(.MAX_PAIRS(MAX_PAIRS), .COL_W(COL_W), .ATTR_W(ATTR_W), .CNT_W(CNT_W)) u_match (
        .col_idx   (sc_q.pos),
        .count     (count),
        .slot_col  (slot_col),
        .slot_attr (slot_attr),
        .hit       (hit),
        .hit_attr  (hit_attr)
    );

    assign cur_attr = hit ? hit_attr : sc_q.held;

    always_comb begin
        sc_d = sc_q;
        if (row_start) begin
            sc_d.pos  = '0;
            sc_d.held = DEFAULT_ATTR;
        end else if (col_adv && (sc_q.pos < LAST_COL)) begin
            sc_d.pos  = sc_q.pos + COL_W'(1);
            sc_d.held = cur_attr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sc_q.pos  <= '0;
            sc_q.held <= DEFAULT_ATTR;
        end else begin
            sc_q <= sc_d;
        end
    end

    AST_ROW_HOME: assert property (@(posedge clk) disable iff (!rst_n)
        row_start |=> (sc_q.pos == '0 && sc_q.held == DEFAULT_ATTR)); // R1
    AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        sc_q.pos <= LAST_COL); // R8
    AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (col_adv && !row_start && sc_q.pos < LAST_COL) |=> (sc_q.pos == $past(sc_q.pos) + COL_W'(1))); // R7
    AST_END_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (col_adv && !row_start && !pair_valid && sc_q.pos == LAST_COL) |=> ($stable(sc_q.pos) && $stable(cur_attr))); // R8
    AST_BAD_COL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_valid && !row_start && pair_col[COL_W-1:0] > LAST_COL) |=> $stable(count)); // R4
    AST_START_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_valid && row_start) |=> (count == '0)); // R9
endmodule

// File: tb/rowattr_decoder_test.sv
module rowattr_decoder_test;
    localparam int         NCOL = 80;
    localparam int         NMAX = 20;
    localparam logic [7:0] DEF  = 8'h07;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       row_start = 1'b0;
    logic       col_adv = 1'b0;
    logic       pair_valid = 1'b0;
    logic [7:0] pair_col = '0;
    logic [7:0] pair_attr = '0;
    logic [7:0] cur_attr;

    int checks = 0;
    int fails  = 0;

    logic [7:0] lc [0:31];
    logic [7:0] la [0:31];
    int         ln = 0;

    always #10 clk = ~clk;

    rowattr_decoder uut (
        .clk(clk), .rst_n(rst_n), .row_start(row_start), .col_adv(col_adv),
        .pair_valid(pair_valid), .pair_col(pair_col), .pair_attr(pair_attr),
        .cur_attr(cur_attr)
    );

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: cur_attr actual %h expected %h", tag, act, exp);
        end
    endtask

    // attribute expected at column c from the bench pair list
    function automatic logic [7:0] exp_at(input int c);
        logic [7:0] a = DEF;
        int best = -1;
        int taken = 0;
        for (int i = 0; i < ln; i++) begin
            int col = int'(lc[i] & 8'h7F);
            if (col < NCOL && taken < NMAX) begin
                taken++;
                if (col <= c && col >= best) begin
                    best = col;
                    a = la[i];
                end
            end
        end
        return a;
    endfunction

    task automatic new_row();
        row_start = 1'b1;
        step();
        row_start = 1'b0;
        ln = 0;
    endtask

    task automatic add(input logic [7:0] c, input logic [7:0] a);
        lc[ln] = c;
        la[ln] = a;
        ln++;
        pair_valid = 1'b1;
        pair_col = c;
        pair_attr = a;
        step();
        pair_valid = 1'b0;
    endtask

    task automatic scan(input string tag);
        chk(tag, cur_attr, exp_at(0));
        for (int c = 1; c < NCOL; c++) begin
            col_adv = 1'b1;
            step();
            col_adv = 1'b0;
            chk(tag, cur_attr, exp_at(c));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not end, actual running expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED1234));
        step();
        chk("R1 reset", cur_attr, DEF);
        rst_n = 1'b1;
        step();

        // R2 basic changes, default before first change
        new_row();
        add(8'd5, 8'h11); add(8'd20, 8'h22); add(8'd79, 8'h33);
        scan("R2");

        // R8 advance at the last column has no effect
        col_adv = 1'b1; step(); col_adv = 1'b0;
        chk("R8", cur_attr, 8'h33);

        // R1 row start back to default and column 0
        new_row();
        chk("R1 row start", cur_attr, DEF);

        // R3 bit 7 ignored, R4 off-line columns dropped
        new_row();
        add(8'h80, 8'h41); add(8'h50, 8'h42); add(8'h60, 8'h43);
        add(8'h7F, 8'h44); add(8'h8A, 8'h45); add(8'hD0, 8'h46);
        chk("R3 col 0x80", cur_attr, 8'h41);
        scan("R3_R4");

        // R5 capacity: 20 accepted, later ones discarded
        new_row();
        for (int i = 0; i < 23; i++) add(8'(i * 3), 8'(8'h60 + i));
        scan("R5");

        // R5 invalid pairs take no slot, the 20th valid one is kept
        new_row();
        add(8'h55, 8'hEE); add(8'h60, 8'hEF);
        for (int i = 0; i < 21; i++) add(8'(i * 2 + 30), 8'(8'hA0 + i));
        scan("R5 skip");

        // R6 duplicates: later wins
        new_row();
        add(8'd10, 8'h01); add(8'd30, 8'h02); add(8'd10, 8'h03); add(8'h9E, 8'h04);
        scan("R6");

        // R9 pair with row start is dropped
        pair_valid = 1'b1; pair_col = 8'd0; pair_attr = 8'hAA;
        row_start = 1'b1;
        step();
        row_start = 1'b0; pair_valid = 1'b0; ln = 0;
        scan("R9");

        // R10 row start wins over advance
        col_adv = 1'b1; row_start = 1'b1;
        step();
        col_adv = 1'b0; row_start = 1'b0; ln = 0;
        add(8'd0, 8'h31);
        chk("R10", cur_attr, 8'h31);

        // R7 random rows with per-column checks
        for (int r = 0; r < 40; r++) begin
            int n = int'($urandom % 29);
            new_row();
            for (int i = 0; i < n; i++) begin
                logic [7:0] c;
                case ($urandom % 4)
                    0: c = 8'($urandom % 80);
                    1: c = 8'($urandom % 80) | 8'h80;
                    2: c = 8'(8'h50 + ($urandom % 48));
                    default: c = 8'($urandom % 256);
                endcase
                add(c, 8'($urandom));
            end
            scan("R7 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule